// File: doc/BRIEF.md
# Torus Route Selector

This unit makes the per-hop routing decision for one router in a two-dimensional torus. The router presents a head flit's current and destination coordinates, the dimension and virtual-channel class the flit arrived on, and a four-bit congestion hint, one bit per outgoing ring direction. The unit answers on the next clock with a one-hot output-port request, the virtual-channel class for the next hop and the dimension it chose.

Both ways around a ring are candidates. The short way gets the larger weight, and a direction flagged as congested has its weight halved. An internal 16-bit LFSR supplies one random draw per decision. When both offsets are nonzero, one LFSR bit picks the dimension, so the dimension choice ignores congestion. The low LFSR bits, scaled by the weight sum, pick the ring direction. A flit that has arrived is steered to the local port.

The virtual-channel class stays the same while the flit continues in the same dimension. It starts again at zero on a new dimension or at injection. It rises by one, capped at two, on the hop that crosses a ring's wrap-around link. The result is held until the downstream stage acknowledges it.

Top module: `torus_route_sel`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: When cur_x==dst_x and cur_y==dst_y, the accepted decision is out_port=5'b10000 (local), out_vc=0 and out_dim=0.
- R3: In a ring of K nodes, with forward distance f=(dst-cur) mod K, the forward weight is K-f and the backward weight is f. A set congestion bit replaces that direction's weight with floor(w/2), but never less than 1. Congestion bits: [0] east, [1] west, [2] north, [3] south.
- R4: With r = LFSR bits [7:0] and S the sum of the two weights, the flit goes forward (east for X, north for Y) when floor(r*S/256) is less than the forward weight. Otherwise it goes backward (west or south).
- R5: When only one offset is nonzero, that dimension is used. When both are nonzero, LFSR bit 15 = 1 selects Y and 0 selects X. out_dim is 0 for X and 1 for Y.
- R6: The LFSR resets to 16'hACE1 and steps as next = {q[14:0], q[15]^q[13]^q[12]^q[10]}. It steps exactly once per accepted head flit, local decisions included. A decision uses the value held before that step.
- R7: The base class is in_vc when in_inject=0 and the chosen dimension equals in_dim, and 0 otherwise. out_vc is base+1, capped at 2, when the chosen hop crosses the wrap link: east from x=KX-1, west from x=0, north from y=KY-1, south from y=0. Otherwise out_vc is the base.
- R8: out_port is one-hot: bit0 east, bit1 west, bit2 north, bit3 south, bit4 local.
- R9: in_ready = !out_valid || out_ack. A head flit is accepted on a clock edge with in_valid && in_ready, and its decision appears on that edge. The outputs stay stable while out_valid=1 and out_ack=0. An acknowledge with no new acceptance clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head flit present |
| in_ready | output | 1 | Unit can take a head flit this cycle |
| cur_x | input | XW | This node's X coordinate |
| cur_y | input | YW | This node's Y coordinate |
| dst_x | input | XW | Destination X coordinate |
| dst_y | input | YW | Destination Y coordinate |
| in_inject | input | 1 | Flit enters the network at this node |
| in_dim | input | 1 | Dimension of the arriving hop (0 X, 1 Y) |
| in_vc | input | 2 | Virtual-channel class of the arriving hop |
| cong | input | 4 | Congestion hints: E, W, N, S |
| out_valid | output | 1 | Decision held on the outputs |
| out_ack | input | 1 | Downstream takes the decision |
| out_port | output | 5 | One-hot output-port request |
| out_vc | output | 2 | Virtual-channel class for the next hop |
| out_dim | output | 1 | Dimension chosen |

## Verification
Random traffic is run on a 8-by-5 torus, so that one ring is not a power of two. It mixes arrived flits, single-dimension offsets, two-dimension offsets, every congestion pattern and random acknowledge gaps. Comparing against a behavioural model on every clock separates errors in the weights, the scaling of the draw, the dimension bit and the LFSR stepping. Directed runs from the ring edges with every incoming class exercise the wrap-link escalation, the cap at two and the reset on a dimension change. A stalled-acknowledge sequence with changing inputs shows that held results do not move and that the LFSR does not step. A count over 64 one-hop-east decisions shows that the short way is preferred.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;

    localparam int          LFSR_W   = 16;
    localparam logic [15:0] LFSR_TAP = 16'b1011_0100_0000_0000; // bits 15,13,12,10
    localparam logic [1:0]  VC_TOP   = 2'd2;

    localparam int P_EAST  = 0;
    localparam int P_WEST  = 1;
    localparam int P_NORTH = 2;
    localparam int P_SOUTH = 3;
    localparam int P_LOCAL = 4;
    localparam int NPORT   = 5;

    typedef struct packed {
        logic                valid;
        logic [NPORT-1:0]    port;
        logic [1:0]          vc;
        logic                dim;
        logic [LFSR_W-1:0]   lfsr;
    } rt_state_t;

endpackage

// File: rtl/torus_lfsr_step.sv
module torus_lfsr_step
    import torus_rt_pkg::*;
(
    input  logic [LFSR_W-1:0] cur_state,
    output logic [LFSR_W-1:0] next_state
);
    logic feedback;

    always_comb begin
        feedback   = ^(cur_state & LFSR_TAP);
        next_state = {cur_state[LFSR_W-2:0], feedback};
    end
endmodule

// File: rtl/torus_ring_draw.sv
module torus_ring_draw #(
    parameter int K  = 8,
    parameter int W  = 3,
    parameter int RW = 8
) (
    input  logic [W-1:0]  cur,
    input  logic [W-1:0]  dst,
    input  logic          cong_fwd,
    input  logic          cong_bwd,
    input  logic [RW-1:0] rnd,
    output logic          zero,
    output logic          fwd,
    output logic          wrap
);
    localparam int DW = W + 1;
    localparam int SW = W + 2;
    localparam int PW = RW + SW;

    logic [DW-1:0] dist_f;
    logic [DW-1:0] w_f_raw, w_b_raw;
    logic [DW-1:0] w_f, w_b;
    logic [SW-1:0] w_sum;
    logic [PW-1:0] scaled;
    logic [PW-1:0] limit;

    always_comb begin
        if (dst >= cur) dist_f = DW'(dst) - DW'(cur);
        else            dist_f = DW'(dst) + DW'(K) - DW'(cur);

        w_f_raw = DW'(K) - dist_f;
        w_b_raw = dist_f;

        if (cong_fwd) w_f = ((w_f_raw >> 1) == '0) ? DW'(1) : (w_f_raw >> 1);
        else          w_f = w_f_raw;
        if (cong_bwd) w_b = ((w_b_raw >> 1) == '0) ? DW'(1) : (w_b_raw >> 1);
        else          w_b = w_b_raw;

        w_sum  = SW'(w_f) + SW'(w_b);
        scaled = PW'(rnd) * PW'(w_sum);
        limit  = PW'(w_f) << RW;

        zero = (dist_f == '0);
        fwd  = (scaled < limit);
        wrap = fwd ? (cur == W'(K - 1)) : (cur == '0);
    end
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
    import torus_rt_pkg::*;
#(
    parameter int          KX   = 8,
    parameter int          KY   = 8,
    parameter int          RW   = 8,
    parameter logic [15:0] SEED = 16'hACE1,
    localparam int         XW   = (KX > 1) ? $clog2(KX) : 1,
    localparam int         YW   = (KY > 1) ? $clog2(KY) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic          in_inject,
    input  logic          in_dim,
    input  logic [1:0]    in_vc,
    input  logic [3:0]    cong,
    output logic          out_valid,
    input  logic          out_ack,
    output logic [4:0]    out_port,
    output logic [1:0]    out_vc,
    output logic          out_dim
);
    rt_state_t st_d, st_q;

    logic [LFSR_W-1:0] lfsr_nxt;
    logic              zx, fx, wx;
    logic              zy, fy, wy;
    logic              accept;
    logic              use_y;
    logic              crossed;
    logic [1:0]        vc_base;

    torus_lfsr_step u_lfsr (
        .cur_state  (st_q.lfsr),
        .next_state (lfsr_nxt)
    );

    torus_ring_draw #(.K(KX), .W(XW), .RW(RW)) u_draw_x (
        .cur      (cur_x),
        .dst      (dst_x),
        .cong_fwd (cong[P_EAST]),
        .cong_bwd (cong[P_WEST]),
        .rnd      (st_q.lfsr[RW-1:0]),
        .zero     (zx),
        .fwd      (fx),
        .wrap     (wx)
    );

    torus_ring_draw #(.K(KY), .W(YW), .RW(RW)) u_draw_y (
        .cur      (cur_y),
        .dst      (dst_y),
        .cong_fwd (cong[P_NORTH]),
        .cong_bwd (cong[P_SOUTH]),
        .rnd      (st_q.lfsr[RW-1:0]),
        .zero     (zy),
        .fwd      (fy),
        .wrap     (wy)
    );

    assign in_ready = !st_q.valid || out_ack;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d    = st_q;
        use_y   = 1'b0;
        crossed = 1'b0;
        vc_base = 2'd0;

        if (st_q.valid && out_ack) st_d.valid = 1'b0;

        if (accept) begin
            st_d.valid = 1'b1;
            st_d.lfsr  = lfsr_nxt;
            if (zx && zy) begin
                st_d.port = NPORT'(1) << P_LOCAL;
                st_d.vc   = 2'd0;
                st_d.dim  = 1'b0;
            end else begin
                if (zx)      use_y = 1'b1;
                else if (zy) use_y = 1'b0;
                else         use_y = st_q.lfsr[LFSR_W-1];

                if (use_y) begin
                    st_d.port = NPORT'(1) << (fy ? P_NORTH : P_SOUTH);
                    crossed   = wy;
                end else begin
                    st_d.port = NPORT'(1) << (fx ? P_EAST : P_WEST);
                    crossed   = wx;
                end

                if (!in_inject && (in_dim == use_y))
                    vc_base = (in_vc > VC_TOP) ? VC_TOP : in_vc;

                if (crossed && vc_base < VC_TOP) st_d.vc = vc_base + 2'd1;
                else                             st_d.vc = vc_base;
                st_d.dim = use_y;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.port  <= '0;
            st_q.vc    <= '0;
            st_q.dim   <= 1'b0;
            st_q.lfsr  <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_port  = st_q.port;
    assign out_vc    = st_q.vc;
    assign out_dim   = st_q.dim;

    assert_port_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_port) == 1));

    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(out_port) && $stable(out_vc) && $stable(out_dim)));

    assert_arrived_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cur_x == dst_x && cur_y == dst_y) |=> (out_port == 5'b10000));

    assert_single_dim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cur_x == dst_x && cur_y != dst_y) |=> (out_dim && out_port[P_LOCAL] == 1'b0));

    assert_vc_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vc <= VC_TOP));

    assert_lfsr_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ack && !in_valid) |=> !out_valid);
endmodule

// File: tb/torus_route_sel_test.sv
module torus_route_sel_test;
    localparam int KX = 8;
    localparam int KY = 5;
    localparam int XW = 3;
    localparam int YW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [XW-1:0] cur_x = '0, dst_x = '0;
    logic [YW-1:0] cur_y = '0, dst_y = '0;
    logic in_inject = 1'b0;
    logic in_dim = 1'b0;
    logic [1:0] in_vc = 2'd0;
    logic [3:0] cong = 4'd0;
    logic out_valid;
    logic out_ack = 1'b0;
    logic [4:0] out_port;
    logic [1:0] out_vc;
    logic out_dim;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    torus_route_sel #(.KX(KX), .KY(KY)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .in_inject(in_inject), .in_dim(in_dim), .in_vc(in_vc), .cong(cong),
        .out_valid(out_valid), .out_ack(out_ack), .out_port(out_port),
        .out_vc(out_vc), .out_dim(out_dim)
    );

    // behavioural reference
    int m_valid = 0, m_port = 0, m_vc = 0, m_dim = 0;
    int m_lfsr = 16'hACE1;

    function automatic int lfsr_next(int v);
        int fb;
        fb = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
        return ((v << 1) | fb) & 16'hFFFF;
    endfunction

    // returns 1 for forward; wr set when hop uses the wrap link
    function automatic int pick_dir(int k, int c, int d, int cf, int cb, int r, output int wr);
        int f, wf, wb, t, fw;
        f  = (d - c + k) % k;
        wf = k - f;
        wb = f;
        if (cf != 0) begin wf = wf / 2; if (wf < 1) wf = 1; end
        if (cb != 0) begin wb = wb / 2; if (wb < 1) wb = 1; end
        t  = ((r % 256) * (wf + wb)) / 256;
        fw = (t < wf) ? 1 : 0;
        wr = fw ? ((c == k - 1) ? 1 : 0) : ((c == 0) ? 1 : 0);
        return fw;
    endfunction

    always @(posedge clk) begin
        int rdy, fw, wr, ydim, base;
        if (!rst_n) begin
            m_valid = 0; m_port = 0; m_vc = 0; m_dim = 0; m_lfsr = 16'hACE1;
        end else begin
            rdy = (!m_valid || out_ack) ? 1 : 0;
            if (in_valid && rdy) begin
                m_valid = 1;
                if (cur_x == dst_x && cur_y == dst_y) begin
                    m_port = 16; m_vc = 0; m_dim = 0;
                end else begin
                    if (cur_x == dst_x)      ydim = 1;
                    else if (cur_y == dst_y) ydim = 0;
                    else                     ydim = (m_lfsr >> 15) & 1;
                    if (ydim) begin
                        fw = pick_dir(KY, cur_y, dst_y, cong[2], cong[3], m_lfsr, wr);
                        m_port = fw ? 4 : 8;
                    end else begin
                        fw = pick_dir(KX, cur_x, dst_x, cong[0], cong[1], m_lfsr, wr);
                        m_port = fw ? 1 : 2;
                    end
                    base = (!in_inject && in_dim == ydim) ? in_vc : 0;
                    if (base > 2) base = 2;
                    m_vc  = (wr && base < 2) ? base + 1 : base;
                    m_dim = ydim;
                end
                m_lfsr = lfsr_next(m_lfsr);
            end else if (out_ack) begin
                m_valid = 0;
            end
        end
    end

    task automatic check();
        int exp_rdy;
        vectors++;
        exp_rdy = (!m_valid || out_ack) ? 1 : 0;
        if (out_valid !== 1'(m_valid)) begin
            fails++;
            $display("FAIL R1/R9 out_valid actual %0b expected %0d", out_valid, m_valid);
        end
        if (in_ready !== 1'(exp_rdy)) begin
            fails++;
            $display("FAIL R1/R9 in_ready actual %0b expected %0d", in_ready, exp_rdy);
        end
        if (m_valid) begin
            if (out_port !== 5'(m_port)) begin
                fails++;
                if (m_port == 16) $display("FAIL R2/R8 out_port actual %b expected %b", out_port, 5'(m_port));
                else $display("FAIL R3/R4/R6/R8 out_port actual %b expected %b", out_port, 5'(m_port));
            end
            if (out_dim !== 1'(m_dim)) begin
                fails++;
                $display("FAIL R5 out_dim actual %0b expected %0d", out_dim, m_dim);
            end
            if (out_vc !== 2'(m_vc)) begin
                fails++;
                $display("FAIL R7 out_vc actual %0d expected %0d", out_vc, m_vc);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check();
    endtask

    task automatic put(int v, int cx, int cy, int dx, int dy, int inj, int dm, int vc, int cg, int ak);
        in_valid = 1'(v); cur_x = XW'(cx); cur_y = YW'(cy); dst_x = XW'(dx); dst_y = YW'(dy);
        in_inject = 1'(inj); in_dim = 1'(dm); in_vc = 2'(vc); cong = 4'(cg); out_ack = 1'(ak);
    endtask

    initial begin
        int east_cnt;
        // R1: reset state
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R2: arrived flit goes local
        put(1, 3, 2, 3, 2, 0, 1, 2, 0, 1); tick();
        put(1, 0, 0, 0, 0, 1, 0, 0, 15, 1); tick();

        // R9, R6: stalled acknowledge with changing inputs, result must hold
        put(1, 1, 1, 6, 3, 1, 0, 0, 0, 0); tick();
        for (int i = 0; i < 4; i++) begin
            put(1, i, i % KY, 7 - i, 4 - (i % KY), 0, i & 1, i % 3, i, 0); tick();
        end
        put(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();

        // R7: wrap-link hops from ring edges with every incoming class
        for (int vc = 0; vc < 3; vc++) begin
            for (int d = 0; d < 2; d++) begin
                put(1, KX - 1, 0, 0, 0, 0, d, vc, 0, 1); tick();
                put(1, 0, 0, KX - 1, 0, 0, d, vc, 0, 1); tick();
                put(1, 2, KY - 1, 2, 0, 0, d, vc, 0, 1); tick();
                put(1, 2, 0, 2, KY - 1, 0, d, vc, 0, 1); tick();
                put(1, KX - 1, KY - 1, 0, 0, 1, d, vc, 0, 1); tick();
            end
        end

        // R3, R4: one hop east, short way should dominate
        east_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            put(1, 0, 0, 1, 0, 1, 0, 0, 0, 1); tick();
            if (out_port == 5'b00001) east_cnt++;
        end
        vectors++;
        if (east_cnt < 40) begin
            fails++;
            $display("FAIL R3 east decisions actual %0d expected >= 40", east_cnt);
        end

        // R3, R4, R5, R7, R9: random traffic with congestion and ack gaps
        for (int i = 0; i < 4000; i++) begin
            int cx, cy, dx, dy;
            cx = $urandom_range(KX - 1); cy = $urandom_range(KY - 1);
            dx = ($urandom_range(5) == 0) ? cx : $urandom_range(KX - 1);
            dy = ($urandom_range(5) == 0) ? cy : $urandom_range(KY - 1);
            put($urandom_range(3) != 0, cx, cy, dx, dy, $urandom_range(3) == 0,
                $urandom_range(1), $urandom_range(2), $urandom_range(15), $urandom_range(2) != 0);
            tick();
        end

        put(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule